// File: doc/BRIEF.md
# Tiled Surface Address Walker

This block turns a rectangular region of a 2D surface into a stream of linear byte addresses, one per element, in raster order: left to right along a row, then down to the next row. The surface may be stored linearly or in one of three 4096-byte tile layouts. The layouts are a row-major byte tile, a tile of 16-byte units ordered column-major, and a tile of nested pixel blocks. A memory engine behind the walker consumes the addresses; the walker itself performs no memory access.

A walk is set up by a one-cycle start pulse that captures the region origin (byte column and row), the element count per row, the row count, the surface stride in bytes, the tiling mode, an optional bit-6 address swizzle and the byte step between adjacent elements. Addresses leave through a valid/ready handshake. A done flag marks the final address of the region.

Top module: `tiled_addr_walker`

## Requirements
- R1: With mode_i = 0 (linear) the address is y * stride + x, and swz_en_i has no effect on it.
- R2: With mode_i = 1 (X tiles, 512 bytes by 8 rows) the address is tile*4096 + (y mod 8)*512 + (x mod 512), where tile = (y/8)*(stride/512) + x/512.
- R3: With mode_i = 2 (Y tiles, 128 bytes by 32 rows) the address is tile*4096 + unit*16 + (x mod 16), where unit = ((x mod 128)/16)*32 + (y mod 32) and tile = (y/32)*(stride/128) + x/128.
- R4: With mode_i = 3 (W tiles, 64 by 64) the address is tile*4096 + b8*64 + b4*16 + b2*4 + b1, where tile = (y/64)*(stride/64) + x/64, b8 = ((x/8) mod 8)*8 + (y/8) mod 8, and b4, b2, b1 are each (y bit)*2 + (x bit) for bit 2, bit 1 and bit 0 of x and y.
- R5: With swz_en_i = 1 in mode 1, bit 6 of the tiled address is replaced by bit6 XOR bit9 XOR bit10; no other bit changes.
- R6: With swz_en_i = 1 in modes 2 and 3, bit 6 of the tiled address is replaced by bit6 XOR bit9; no other bit changes.
- R7: Addresses come in raster order: x starts at x0_i and grows by step_i per element; after width_i elements x returns to x0_i and y grows by one. The first address is valid in the cycle after the start pulse.
- R8: done_o is high together with the final address of the region only, and valid_o falls once that address is accepted.
- R9: While valid_o is high and ready_i is low, addr_o and done_o hold their values and valid_o stays high.
- R10: A start pulse during a walk is ignored; the running walk completes with its original settings.
- R11: A start with width_i = 0 or height_i = 0 produces no address and leaves the walker idle.
- R12: After reset valid_o and done_o are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle pulse that begins a walk when idle |
| mode_i | input | 2 | Layout: 0 linear, 1 X, 2 Y, 3 W |
| swz_en_i | input | 1 | Enable bit-6 swizzle in tiled modes |
| x0_i | input | 16 | Starting byte column |
| y0_i | input | 16 | Starting row |
| width_i | input | 16 | Elements per row |
| height_i | input | 16 | Number of rows |
| stride_i | input | 32 | Surface stride in bytes, a multiple of the tile width |
| step_i | input | 8 | Byte step between elements in a row |
| ready_i | input | 1 | Consumer accepts the current address |
| valid_o | output | 1 | An address is presented |
| addr_o | output | 32 | Linear byte address of the current element |
| done_o | output | 1 | Current address is the last of the region |

## Verification
The bench goes after tile-boundary crossings in each layout (x passing 512, 128 or 64 bytes, y passing 8, 32 or 64 rows), where a wrong shift or mask would put addresses in the wrong tile or scramble the unit order inside it. It picks rows whose address bits 9 and 10 differ, so that a swizzle applying the wrong rule for the mode, or touching linear mode, flips bit 6 wrongly. It stalls the consumer at random; a walker that advanced on an unaccepted beat would skip an address. It also pulses start in mid-walk and with an empty region: a walker that restarted would repeat addresses, and one that accepted a zero size would emit a spurious address.

// File: rtl/tw_pkg.sv
package tw_pkg;
  typedef enum logic [1:0] {
    TM_LINEAR = 2'd0,
    TM_XMAJ   = 2'd1,
    TM_YMAJ   = 2'd2,
    TM_WBLK   = 2'd3
  } tmode_e;

  localparam int TILE_LOG2 = 12;
endpackage

// File: rtl/tw_tile_map.sv
module tw_tile_map
  import tw_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  tmode_e        mode,
  input  logic [CW-1:0] px,
  input  logic [CW-1:0] py,
  input  logic [AW-1:0] stride,
  output logic [AW-1:0] addr
);
  logic [AW-1:0] xw, yw, tpr, tile;
  logic [TILE_LOG2-1:0] inner;

  always_comb begin
    xw    = AW'(px);
    yw    = AW'(py);
    tpr   = '0;
    tile  = '0;
    inner = '0;
    addr  = '0;
    unique case (mode)
      TM_LINEAR: begin
        addr = yw * stride + xw;
      end
      TM_XMAJ: begin
        tpr   = stride >> 9;
        tile  = (yw >> 3) * tpr + (xw >> 9);
        inner = {py[2:0], px[8:0]};
        addr  = (tile << TILE_LOG2) | AW'(inner);
      end
      TM_YMAJ: begin
        tpr   = stride >> 7;
        tile  = (yw >> 5) * tpr + (xw >> 7);
        inner = {px[6:4], py[4:0], px[3:0]};
        addr  = (tile << TILE_LOG2) | AW'(inner);
      end
      default: begin
        tpr   = stride >> 6;
        tile  = (yw >> 6) * tpr + (xw >> 6);
        inner = {px[5:3], py[5:3], py[2], px[2], py[1], px[1], py[0], px[0]};
        addr  = (tile << TILE_LOG2) | AW'(inner);
      end
    endcase
  end
endmodule

// File: rtl/tw_swizzle.sv
module tw_swizzle
  import tw_pkg::*;
#(
  parameter int AW = 32
) (
  input  tmode_e        mode,
  input  logic          en,
  input  logic [AW-1:0] raw,
  output logic [AW-1:0] out
);
  logic flip;

  always_comb begin
    flip = raw[9] ^ ((mode == TM_XMAJ) ? raw[10] : 1'b0);
    out  = raw;
    if (en && (mode != TM_LINEAR)) begin
      out[6] = raw[6] ^ flip;
    end
  end
endmodule

// File: rtl/tw_iter.sv
module tw_iter #(
  parameter int CW = 16,
  parameter int SW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] x0,
  input  logic [CW-1:0] y0,
  input  logic [CW-1:0] width,
  input  logic [CW-1:0] height,
  input  logic [SW-1:0] step,
  input  logic          ready,
  output logic          accept,
  output logic          active,
  output logic          last,
  output logic [CW-1:0] cur_x,
  output logic [CW-1:0] cur_y
);
  logic          active_q, active_n;
  logic [CW-1:0] x_q, x_n, y_q, y_n, col_q, col_n, row_q, row_n;
  logic [CW-1:0] x0_q, x0_n, wl_q, wl_n, hl_q, hl_n;
  logic [SW-1:0] step_q, step_n;
  logic          last_col, last_row, en;

  assign last_col = (col_q == wl_q);
  assign last_row = (row_q == hl_q);

  always_comb begin
    active_n = active_q;
    x_n      = x_q;
    y_n      = y_q;
    col_n    = col_q;
    row_n    = row_q;
    x0_n     = x0_q;
    wl_n     = wl_q;
    hl_n     = hl_q;
    step_n   = step_q;
    accept   = 1'b0;
    if (!active_q) begin
      if (start && (width != '0) && (height != '0)) begin
        accept   = 1'b1;
        active_n = 1'b1;
        x_n      = x0;
        y_n      = y0;
        col_n    = '0;
        row_n    = '0;
        x0_n     = x0;
        wl_n     = width - 1'b1;
        hl_n     = height - 1'b1;
        step_n   = step;
      end
    end else if (ready) begin
      if (last_col) begin
        col_n = '0;
        x_n   = x0_q;
        if (last_row) begin
          active_n = 1'b0;
        end else begin
          row_n = row_q + 1'b1;
          y_n   = y_q + 1'b1;
        end
      end else begin
        col_n = col_q + 1'b1;
        x_n   = x_q + CW'(step_q);
      end
    end
  end

  assign en = accept | (active_q & ready);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      x_q      <= '0;
      y_q      <= '0;
      col_q    <= '0;
      row_q    <= '0;
      x0_q     <= '0;
      wl_q     <= '0;
      hl_q     <= '0;
      step_q   <= '0;
    end else if (en) begin
      active_q <= active_n;
      x_q      <= x_n;
      y_q      <= y_n;
      col_q    <= col_n;
      row_q    <= row_n;
      x0_q     <= x0_n;
      wl_q     <= wl_n;
      hl_q     <= hl_n;
      step_q   <= step_n;
    end
  end

  assign active = active_q;
  assign last   = active_q & last_col & last_row;
  assign cur_x  = x_q;
  assign cur_y  = y_q;
endmodule

// File: rtl/tiled_addr_walker.sv
module tiled_addr_walker
  import tw_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16,
  parameter int SW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [1:0]    mode_i,
  input  logic          swz_en_i,
  input  logic [CW-1:0] x0_i,
  input  logic [CW-1:0] y0_i,
  input  logic [CW-1:0] width_i,
  input  logic [CW-1:0] height_i,
  input  logic [AW-1:0] stride_i,
  input  logic [SW-1:0] step_i,
  input  logic          ready_i,
  output logic          valid_o,
  output logic [AW-1:0] addr_o,
  output logic          done_o
);
  logic          rst_s1, rst_s2;
  logic          accept, active, last;
  logic [CW-1:0] cur_x, cur_y;
  tmode_e        mode_q;
  logic          swz_q;
  logic [AW-1:0] stride_q, raw_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_s2 <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_s2 <= rst_s1;
    end
  end

  always_ff @(posedge clk or negedge rst_s2) begin
    if (!rst_s2) begin
      mode_q   <= TM_LINEAR;
      swz_q    <= 1'b0;
      stride_q <= '0;
    end else if (accept) begin
      mode_q   <= tmode_e'(mode_i);
      swz_q    <= swz_en_i;
      stride_q <= stride_i;
    end
  end

  tw_iter #(.CW(CW), .SW(SW)) u_iter (
    .clk    (clk),
    .rst_n  (rst_s2),
    .start  (start_i),
    .x0     (x0_i),
    .y0     (y0_i),
    .width  (width_i),
    .height (height_i),
    .step   (step_i),
    .ready  (ready_i),
    .accept (accept),
    .active (active),
    .last   (last),
    .cur_x  (cur_x),
    .cur_y  (cur_y)
  );

  tw_tile_map #(.AW(AW), .CW(CW)) u_map (
    .mode   (mode_q),
    .px     (cur_x),
    .py     (cur_y),
    .stride (stride_q),
    .addr   (raw_addr)
  );

  tw_swizzle #(.AW(AW)) u_swz (
    .mode (mode_q),
    .en   (swz_q),
    .raw  (raw_addr),
    .out  (addr_o)
  );

  assign valid_o = active;
  assign done_o  = last;
endmodule

// File: rtl/tw_checker.sv
module tw_checker #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          valid,
  input logic          ready,
  input logic [AW-1:0] addr,
  input logic          done
);
  // R9: stalled beat holds
  a_r9_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready) |=> (valid && $stable(addr) && $stable(done)));

  // R8: done only with a presented address
  a_r8_done_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> valid);

  // R8: accepted final address ends the walk
  a_r8_end_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && ready && done) |=> !valid);

  // R10: a walk never stops before its final address is taken
  a_r10_no_early_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !(ready && done)) |=> valid);
endmodule

bind tiled_addr_walker tw_checker #(.AW(AW)) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .valid (valid_o),
  .ready (ready_i),
  .addr  (addr_o),
  .done  (done_o)
);

// File: tb/sim_tiled_addr_walker.sv
module sim_tiled_addr_walker;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [1:0]  mode_i = '0;
  logic        swz_en_i = 1'b0;
  logic [15:0] x0_i = '0, y0_i = '0, width_i = '0, height_i = '0;
  logic [31:0] stride_i = '0;
  logic [7:0]  step_i = '0;
  logic        ready_i = 1'b0;
  logic        valid_o, done_o;
  logic [31:0] addr_o;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tiled_addr_walker u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
    .swz_en_i(swz_en_i), .x0_i(x0_i), .y0_i(y0_i), .width_i(width_i),
    .height_i(height_i), .stride_i(stride_i), .step_i(step_i),
    .ready_i(ready_i), .valid_o(valid_o), .addr_o(addr_o), .done_o(done_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int unsigned ref_addr(input int mode, input bit swz,
      input int unsigned x, input int unsigned y, input int unsigned stride);
    int unsigned a, tile, unit, b8, b4, b2, b1, flip;
    case (mode)
      0: a = y * stride + x;
      1: begin
        tile = (y / 8) * (stride / 512) + x / 512;
        a = tile * 4096 + (y % 8) * 512 + x % 512;
      end
      2: begin
        tile = (y / 32) * (stride / 128) + x / 128;
        unit = ((x % 128) / 16) * 32 + y % 32;
        a = tile * 4096 + unit * 16 + x % 16;
      end
      default: begin
        tile = (y / 64) * (stride / 64) + x / 64;
        b8 = ((x / 8) % 8) * 8 + (y / 8) % 8;
        b4 = ((y / 4) % 2) * 2 + (x / 4) % 2;
        b2 = ((y / 2) % 2) * 2 + (x / 2) % 2;
        b1 = (y % 2) * 2 + x % 2;
        a = tile * 4096 + b8 * 64 + b4 * 16 + b2 * 4 + b1;
      end
    endcase
    if (swz && mode != 0) begin
      flip = (a / 512) % 2;
      if (mode == 1) flip = flip ^ ((a / 1024) % 2);
      if (flip != 0) a = a ^ 32'd64;
    end
    return a;
  endfunction

  function automatic string tag_of(input int mode, input bit swz);
    if (swz && mode == 1) return "R5";
    if (swz && mode > 1) return "R6";
    case (mode)
      0: return "R1";
      1: return "R2";
      2: return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic run_walk(input int mode, input bit swz, input int x0, input int y0,
      input int w, input int h, input int stride, input int step, input bit inject);
    int n, idx, cyc;
    bit stalled;
    logic [31:0] held;
    string tag;
    tag = tag_of(mode, swz);
    n = w * h;
    @(negedge clk);
    mode_i = 2'(mode); swz_en_i = swz; x0_i = 16'(x0); y0_i = 16'(y0);
    width_i = 16'(w); height_i = 16'(h); stride_i = 32'(stride); step_i = 8'(step);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    #1;
    check("R7 first valid after start", 32'(valid_o), 32'd1);
    idx = 0; cyc = 0; stalled = 1'b0; held = '0;
    while (idx < n && cyc < 5000) begin
      ready_i = ($urandom % 3) != 0;
      if (inject && cyc == 3) begin
        start_i = 1'b1; mode_i = 2'd0; x0_i = 16'd7; y0_i = 16'd9;
        width_i = 16'd2; height_i = 16'd2; stride_i = 32'd64; step_i = 8'd1;
      end else begin
        start_i = 1'b0;
      end
      #1;
      if (stalled) begin
        check("R9 held addr", addr_o, held);
        check("R9 held valid", 32'(valid_o), 32'd1);
      end
      stalled = 1'b0;
      if (valid_o && ready_i) begin
        check(inject ? "R10 addr after stray start" : {tag, "/R7 addr"}, addr_o,
              ref_addr(mode, swz, 32'(x0 + (idx % w) * step), 32'(y0 + idx / w), 32'(stride)));
        check("R8 done flag", 32'(done_o), (idx == n - 1) ? 32'd1 : 32'd0);
        idx++;
      end else if (valid_o) begin
        stalled = 1'b1;
        held = addr_o;
      end
      @(negedge clk);
      cyc++;
    end
    start_i = 1'b0;
    ready_i = 1'b0;
    #1;
    check("R8 valid low after last", 32'(valid_o), 32'd0);
    check("R8 walk complete", 32'(idx), 32'(n));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    #(CLK_PERIOD * 2);
    #1;
    check("R12 valid at reset", 32'(valid_o), 32'd0);
    check("R12 done at reset", 32'(done_o), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R12 idle after reset", 32'(valid_o), 32'd0);

    // directed corner cases
    run_walk(0, 1'b1, 30, 5, 4, 3, 96, 3, 1'b0);      // linear, swizzle ignored
    run_walk(1, 1'b0, 504, 6, 4, 4, 1536, 4, 1'b0);   // X: cross 512 and row 8
    run_walk(2, 1'b0, 120, 30, 3, 4, 512, 4, 1'b0);   // Y: cross 128 and row 32
    run_walk(3, 1'b0, 60, 62, 3, 4, 256, 2, 1'b0);    // W: cross 64 both ways
    run_walk(1, 1'b1, 0, 1, 3, 6, 2048, 64, 1'b0);    // X swizzle, bits 9/10 vary
    run_walk(2, 1'b1, 64, 0, 3, 3, 256, 16, 1'b0);    // Y swizzle
    run_walk(3, 1'b1, 8, 8, 4, 3, 128, 8, 1'b0);      // W swizzle
    run_walk(2, 1'b0, 16, 3, 3, 3, 512, 8, 1'b1);     // R10 stray start

    // R11: empty regions
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      width_i = (k == 0) ? 16'd0 : 16'd3;
      height_i = (k == 0) ? 16'd4 : 16'd0;
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      repeat (2) @(negedge clk);
      #1;
      check("R11 no address for empty region", 32'(valid_o), 32'd0);
    end

    // constrained random walks
    for (int t = 0; t < 40; t++) begin
      int m, st, sp;
      m  = int'($urandom % 4);
      st = int'((1 + $urandom % 8) * 512);
      sp = 1 << ($urandom % 4);
      run_walk(m, 1'($urandom % 2), int'($urandom % 2048), int'($urandom % 200),
               int'(1 + $urandom % 6), int'(1 + $urandom % 5), st, sp, 1'b0);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule